// File: doc/BRIEF.md
# Status Word Writeback Merger

This block commits one bundle of queued register writes per cycle. A bundle holds a fixed number of entries. Each entry has a valid bit, a target select, a bit mask and a data word. The entries are applied in queue order to four 32-bit architectural registers: the processor status word, its copy saved on a normal trap, its copy saved on a debug trap, and the active stack pointer. An entry changes only the bits its mask selects.

Two entries in one bundle can both write the status word. They normally come from the two halves of a parallel issue. In that case the later entry keeps the arithmetic flags it writes, and the earlier entry gives them up. The earlier entry also gives up its accumulated-overflow bit when the later entry writes the overflow bit. This rule is skipped when the earlier half was a move-to-system-register operation.

After the writes, a trap code can request a normal trap or a debug trap. Each trap saves the status word and then clears it. Last, the stack-pointer bank select follows the stack-mode bit of the final status word. When the select changes, the live stack pointer is swapped against a two-slot bank. All state is registered and becomes visible one clock after `commit_i`.

Top module: `psw_writeback_merger`

## Requirements
- R1: Each valid entry computes new = (old & ~mask) | (data & mask) on its target. Target encoding: 0 = status word, 1 = normal-trap copy, 2 = debug-trap copy, 3 = stack pointer.
- R2: Entries apply in index order, entry 0 first. Each entry sees the result of the entries before it. An entry whose valid bit is low has no effect.
- R3: The arithmetic flags are F0, F1, F2, F3, S, V, VA and C. Status bits are numbered from the MSB, so bit n is 0x80000000 >> n. Default positions are F0=17, F1=19, F2=21, F3=23, S=25, V=27, VA=29, C=31. Take an earlier status-word entry and a later status-word entry whose flag mask overlaps the earlier entry's flag mask. The earlier entry drops the overlapping flags. If the later mask also includes V, the earlier entry drops VA as well.
- R4: When `mvsys_i` is high, the R3 rule is not applied and every entry uses its full mask.
- R5: An entry that targets any register other than the status word never causes R3 suppression.
- R6: Trap code 1 is a normal trap, applied after the writes. The normal-trap copy takes the status word, and the status word keeps only DB (bit 3) and SM (bit 0).
- R7: Trap code 2 is a debug trap, applied after the writes. The debug-trap copy takes the status word, and the status word becomes DS (bit 4) alone. Trap code 0 means no trap, and code 3 is never driven.
- R8: The stack select always equals SM of the status word. When a commit changes it, the stack pointer after the writes is saved to the old bank slot, and the stack pointer is loaded from the new slot.
- R9: With `commit_i` low, no output changes.
- R10: After reset, all four registers, both bank slots and the stack select are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_i | input | 1 | Apply the bundle this cycle |
| ent_valid_i | input | N_ENT | Valid bit of each entry |
| ent_tgt_i | input | N_ENT x 2 | Target select of each entry |
| ent_mask_i | input | N_ENT x DW | Bit mask of each entry |
| ent_data_i | input | N_ENT x DW | Data word of each entry |
| mvsys_i | input | 1 | The earlier half was a move-to-system op |
| trap_i | input | 2 | Trap code: 0 none, 1 normal, 2 debug |
| status_o | output | DW | Status word |
| trap_copy_o | output | DW | Status copy saved on a normal trap |
| dbg_copy_o | output | DW | Status copy saved on a debug trap |
| stack_ptr_o | output | DW | Active stack pointer |
| stack_sel_o | output | 1 | Active stack bank select |

## Verification
The assertions assume that the trap code is never 3 during a commit, and they check this as an input contract. They also assume that entry fields matter only in cycles where `commit_i` is high. The stimulus drives only codes 0 to 2. It holds `commit_i` high for exactly one clock per bundle and changes inputs only on the falling edge. Contention cases are chosen so that the VA suppression is visible at the status word, because a later write to the same flag bits would overwrite them anyway.

// File: rtl/psw_merge_pkg.sv
package psw_merge_pkg;
  typedef enum logic [1:0] {
    TGT_STATUS = 2'd0,
    TGT_TCOPY  = 2'd1,
    TGT_DCOPY  = 2'd2,
    TGT_STACK  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_NORMAL = 2'd1,
    TRAP_DEBUG  = 2'd2,
    TRAP_RSVD   = 2'd3
  } trap_e;
endpackage

// File: rtl/psw_contention.sv
module psw_contention
  import psw_merge_pkg::*;
#(
  parameter int N_ENT = 2,
  parameter int DW = 32,
  parameter logic [DW-1:0] FLAG_MASK = '0,
  parameter logic [DW-1:0] OVF_MASK = '0,
  parameter logic [DW-1:0] ACC_MASK = '0
) (
  input  logic [N_ENT-1:0]         valid_i,
  input  logic [N_ENT-1:0][1:0]    tgt_i,
  input  logic [N_ENT-1:0][DW-1:0] mask_i,
  input  logic                     mvsys_i,
  output logic [N_ENT-1:0][DW-1:0] eff_mask_o
);
  logic [N_ENT-1:0] is_status;

  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_ent
      assign is_status[gi] = valid_i[gi] && (tgt_i[gi] == TGT_STATUS);

      logic [DW-1:0] drop;
      always_comb begin
        drop = '0;
        if (!mvsys_i && is_status[gi]) begin
          for (int j = gi + 1; j < N_ENT; j++) begin
            if (is_status[j] && ((mask_i[j] & mask_i[gi] & FLAG_MASK) != '0)) begin
              drop = drop | (mask_i[j] & mask_i[gi] & FLAG_MASK);
              if ((mask_i[j] & OVF_MASK) != '0) drop = drop | ACC_MASK;
            end
          end
        end
      end
      assign eff_mask_o[gi] = mask_i[gi] & ~drop;
    end
  endgenerate
endmodule

// File: rtl/psw_apply_chain.sv
module psw_apply_chain
  import psw_merge_pkg::*;
#(
  parameter int N_ENT = 2,
  parameter int DW = 32
) (
  input  logic [DW-1:0]            status_i,
  input  logic [DW-1:0]            tcopy_i,
  input  logic [DW-1:0]            dcopy_i,
  input  logic [DW-1:0]            stack_i,
  input  logic [N_ENT-1:0]         valid_i,
  input  logic [N_ENT-1:0][1:0]    tgt_i,
  input  logic [N_ENT-1:0][DW-1:0] mask_i,
  input  logic [N_ENT-1:0][DW-1:0] data_i,
  output logic [DW-1:0]            status_o,
  output logic [DW-1:0]            tcopy_o,
  output logic [DW-1:0]            dcopy_o,
  output logic [DW-1:0]            stack_o
);
  logic [N_ENT:0][DW-1:0] st_s, st_t, st_d, st_p;

  assign st_s[0] = status_i;
  assign st_t[0] = tcopy_i;
  assign st_d[0] = dcopy_i;
  assign st_p[0] = stack_i;

  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_stage
      logic [DW-1:0] m;
      assign m = valid_i[gi] ? mask_i[gi] : '0;
      assign st_s[gi+1] = (tgt_i[gi] == TGT_STATUS) ?
                          ((st_s[gi] & ~m) | (data_i[gi] & m)) : st_s[gi];
      assign st_t[gi+1] = (tgt_i[gi] == TGT_TCOPY) ?
                          ((st_t[gi] & ~m) | (data_i[gi] & m)) : st_t[gi];
      assign st_d[gi+1] = (tgt_i[gi] == TGT_DCOPY) ?
                          ((st_d[gi] & ~m) | (data_i[gi] & m)) : st_d[gi];
      assign st_p[gi+1] = (tgt_i[gi] == TGT_STACK) ?
                          ((st_p[gi] & ~m) | (data_i[gi] & m)) : st_p[gi];
    end
  endgenerate

  assign status_o = st_s[N_ENT];
  assign tcopy_o  = st_t[N_ENT];
  assign dcopy_o  = st_d[N_ENT];
  assign stack_o  = st_p[N_ENT];
endmodule

// File: rtl/psw_writeback_merger.sv
module psw_writeback_merger
  import psw_merge_pkg::*;
#(
  parameter int N_ENT  = 2,
  parameter int DW     = 32,
  parameter int POS_SM = 0,
  parameter int POS_DB = 3,
  parameter int POS_DS = 4,
  parameter int POS_F0 = 17,
  parameter int POS_F1 = 19,
  parameter int POS_F2 = 21,
  parameter int POS_F3 = 23,
  parameter int POS_S  = 25,
  parameter int POS_V  = 27,
  parameter int POS_VA = 29,
  parameter int POS_C  = 31
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit_i,
  input  logic [N_ENT-1:0]         ent_valid_i,
  input  logic [N_ENT-1:0][1:0]    ent_tgt_i,
  input  logic [N_ENT-1:0][DW-1:0] ent_mask_i,
  input  logic [N_ENT-1:0][DW-1:0] ent_data_i,
  input  logic                     mvsys_i,
  input  logic [1:0]               trap_i,
  output logic [DW-1:0]            status_o,
  output logic [DW-1:0]            trap_copy_o,
  output logic [DW-1:0]            dbg_copy_o,
  output logic [DW-1:0]            stack_ptr_o,
  output logic                     stack_sel_o
);
  localparam logic [DW-1:0] TOP_BIT = {1'b1, {(DW-1){1'b0}}};
  localparam int SM_IDX = DW - 1 - POS_SM;
  localparam logic [DW-1:0] SM_MASK = TOP_BIT >> POS_SM;
  localparam logic [DW-1:0] DB_MASK = TOP_BIT >> POS_DB;
  localparam logic [DW-1:0] DS_MASK = TOP_BIT >> POS_DS;
  localparam logic [DW-1:0] V_MASK  = TOP_BIT >> POS_V;
  localparam logic [DW-1:0] VA_MASK = TOP_BIT >> POS_VA;
  localparam logic [DW-1:0] FLAGS   = (TOP_BIT >> POS_F0) | (TOP_BIT >> POS_F1) |
                                      (TOP_BIT >> POS_F2) | (TOP_BIT >> POS_F3) |
                                      (TOP_BIT >> POS_S)  | V_MASK | VA_MASK |
                                      (TOP_BIT >> POS_C);

  logic [N_ENT-1:0][DW-1:0] eff_mask;
  logic [DW-1:0] c_status, c_tcopy, c_dcopy, c_stack;
  logic [DW-1:0] n_status, n_tcopy, n_dcopy;
  logic          n_sel;
  logic [DW-1:0] sp_bank [2];

  psw_contention #(
    .N_ENT(N_ENT), .DW(DW), .FLAG_MASK(FLAGS), .OVF_MASK(V_MASK), .ACC_MASK(VA_MASK)
  ) u_contention (
    .valid_i(ent_valid_i), .tgt_i(ent_tgt_i), .mask_i(ent_mask_i),
    .mvsys_i(mvsys_i), .eff_mask_o(eff_mask)
  );

  psw_apply_chain #(.N_ENT(N_ENT), .DW(DW)) u_chain (
    .status_i(status_o), .tcopy_i(trap_copy_o), .dcopy_i(dbg_copy_o), .stack_i(stack_ptr_o),
    .valid_i(ent_valid_i), .tgt_i(ent_tgt_i), .mask_i(eff_mask), .data_i(ent_data_i),
    .status_o(c_status), .tcopy_o(c_tcopy), .dcopy_o(c_dcopy), .stack_o(c_stack)
  );

  always_comb begin
    n_status = c_status;
    n_tcopy  = c_tcopy;
    n_dcopy  = c_dcopy;
    case (trap_i)
      TRAP_NORMAL: begin
        n_tcopy  = c_status;
        n_status = c_status & (DB_MASK | SM_MASK);
      end
      TRAP_DEBUG: begin
        n_dcopy  = c_status;
        n_status = DS_MASK;
      end
      default: ;
    endcase
    n_sel = n_status[SM_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= '0;
      trap_copy_o <= '0;
      dbg_copy_o  <= '0;
      stack_ptr_o <= '0;
      stack_sel_o <= 1'b0;
      sp_bank[0]  <= '0;
      sp_bank[1]  <= '0;
    end else if (commit_i) begin
      status_o    <= n_status;
      trap_copy_o <= n_tcopy;
      dbg_copy_o  <= n_dcopy;
      stack_sel_o <= n_sel;
      if (n_sel != stack_sel_o) begin
        sp_bank[stack_sel_o] <= c_stack;
        stack_ptr_o          <= sp_bank[n_sel];
      end else begin
        stack_ptr_o <= c_stack;
      end
    end
  end

  a_r7_trap_code_legal: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> (trap_i != TRAP_RSVD));
  a_r3_eff_within_mask: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> ((eff_mask & ~ent_mask_i) == '0));
  a_r4_bypass_full_mask: assert property (@(posedge clk) disable iff (rst)
    (commit_i && mvsys_i) |-> (eff_mask == ent_mask_i));
  a_r6_normal_trap_clear: assert property (@(posedge clk) disable iff (rst)
    (commit_i && trap_i == TRAP_NORMAL) |=> ((status_o & ~(DB_MASK | SM_MASK)) == '0));
  a_r7_debug_trap_only_ds: assert property (@(posedge clk) disable iff (rst)
    (commit_i && trap_i == TRAP_DEBUG) |=> (status_o == DS_MASK));
  a_r8_sel_follows_sm: assert property (@(posedge clk) disable iff (rst)
    stack_sel_o == status_o[SM_IDX]);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(status_o) && $stable(trap_copy_o) && $stable(dbg_copy_o) &&
                   $stable(stack_ptr_o) && $stable(stack_sel_o)));
endmodule

// File: tb/psw_writeback_merger_tb.sv
`timescale 1ns/1ps
module psw_writeback_merger_tb;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic commit = 1'b0;
  logic [N-1:0] valid = '0;
  logic [N-1:0][1:0] tgt = '0;
  logic [N-1:0][31:0] mask = '0;
  logic [N-1:0][31:0] data = '0;
  logic mvsys = 1'b0;
  logic [1:0] trap = 2'd0;
  logic [31:0] status, tcopy, dcopy, sp;
  logic sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psw_writeback_merger u_dut (
    .clk(clk), .rst(rst), .commit_i(commit), .ent_valid_i(valid), .ent_tgt_i(tgt),
    .ent_mask_i(mask), .ent_data_i(data), .mvsys_i(mvsys), .trap_i(trap),
    .status_o(status), .trap_copy_o(tcopy), .dbg_copy_o(dcopy),
    .stack_ptr_o(sp), .stack_sel_o(sel)
  );

  typedef struct packed {
    logic [31:0] preset;
    logic        v0; logic [1:0] t0; logic [31:0] m0; logic [31:0] d0;
    logic        v1; logic [1:0] t1; logic [31:0] m1; logic [31:0] d1;
    logic        mvs;
    logic [1:0]  trp;
    logic [31:0] exp_status;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R1 masked merge
    '{32'h0, 1'b1, 2'd0, 32'h0000FFFF, 32'h00001234, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h00001234, 4'd1},
    '{32'hAAAA0000, 1'b1, 2'd0, 32'h0000FFFF, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'hAAAAFFFF, 4'd1},
    // R2 order and invalid entry
    '{32'h0, 1'b1, 2'd0, 32'h00F00000, 32'h00A00000, 1'b1, 2'd0, 32'h00FF0000, 32'h00550000, 1'b0, 2'd0, 32'h00550000, 4'd2},
    '{32'h00000F00, 1'b0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h00000F00, 4'd2},
    // R3 contention, VA dropped when later writes V
    '{32'h0, 1'b1, 2'd0, 32'h00000014, 32'h00000014, 1'b1, 2'd0, 32'h00000010, 32'h0, 1'b0, 2'd0, 32'h00000000, 4'd3},
    // R4 bypass
    '{32'h0, 1'b1, 2'd0, 32'h00000014, 32'h00000014, 1'b1, 2'd0, 32'h00000010, 32'h0, 1'b1, 2'd0, 32'h00000004, 4'd4},
    // R3 earlier VA clear suppressed
    '{32'h00000004, 1'b1, 2'd0, 32'h00000014, 32'h0, 1'b1, 2'd0, 32'h00000010, 32'h00000010, 1'b0, 2'd0, 32'h00000014, 4'd3},
    // R3 no flag overlap -> no suppression
    '{32'h0, 1'b1, 2'd0, 32'h00000004, 32'h00000004, 1'b1, 2'd0, 32'h00000010, 32'h00000010, 1'b0, 2'd0, 32'h00000014, 4'd3},
    // R3 overlapping S/C flags
    '{32'h0, 1'b1, 2'd0, 32'h00000041, 32'h00000041, 1'b1, 2'd0, 32'h00000001, 32'h0, 1'b0, 2'd0, 32'h00000040, 4'd3},
    // R5 later write to another target
    '{32'h0, 1'b1, 2'd0, 32'h00000014, 32'h00000014, 1'b1, 2'd1, 32'h00000010, 32'h0, 1'b0, 2'd0, 32'h00000014, 4'd5},
    '{32'h0, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h5, 1'b1, 2'd0, 32'h00000014, 32'h00000014, 1'b0, 2'd0, 32'h00000014, 4'd5},
    // R6 normal trap
    '{32'h90005555, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd1, 32'h90000000, 4'd6},
    '{32'h0, 1'b1, 2'd0, 32'hFFFFFFFF, 32'h10000040, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd1, 32'h10000000, 4'd6},
    // R7 debug trap
    '{32'h80001111, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd2, 32'h08000000, 4'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bundle(input logic v0, input logic [1:0] t0, input logic [31:0] m0,
                        input logic [31:0] d0, input logic v1, input logic [1:0] t1,
                        input logic [31:0] m1, input logic [31:0] d1,
                        input logic mv, input logic [1:0] tr);
    @(negedge clk);
    valid = {v1, v0}; tgt[0] = t0; tgt[1] = t1;
    mask[0] = m0; mask[1] = m1; data[0] = d0; data[1] = d1;
    mvsys = mv; trap = tr; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0; valid = '0; trap = 2'd0; mvsys = 1'b0;
  endtask

  task automatic preset(input logic [31:0] v);
    bundle(1'b1, 2'd0, 32'hFFFFFFFF, v, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 status", status, 32'h0);
    check("R10 tcopy", tcopy, 32'h0);
    check("R10 dcopy", dcopy, 32'h0);
    check("R10 sp", sp, 32'h0);
    check("R10 sel", {31'h0, sel}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      preset(VEC[i].preset);
      bundle(VEC[i].v0, VEC[i].t0, VEC[i].m0, VEC[i].d0, VEC[i].v1, VEC[i].t1,
             VEC[i].m1, VEC[i].d1, VEC[i].mvs, VEC[i].trp);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), status, VEC[i].exp_status);
    end

    // R6 saved copy on normal trap
    preset(32'h90005555);
    bundle(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd1);
    check("R6 tcopy", tcopy, 32'h90005555);
    // R7 saved copy on debug trap, normal copy untouched
    preset(32'h80001111);
    bundle(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd2);
    check("R7 dcopy", dcopy, 32'h80001111);
    check("R7 tcopy kept", tcopy, 32'h90005555);
    // R1 masked write to the normal-trap copy
    bundle(1'b1, 2'd1, 32'h0000FF00, 32'h12345678, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0);
    check("R1 tcopy write", tcopy, 32'h90005655);

    // R9 idle cycles ignore inputs
    @(negedge clk);
    valid = 2'b11; tgt = '0; mask[0] = 32'hFFFFFFFF; data[0] = 32'hDEADBEEF; trap = 2'd1;
    repeat (2) @(negedge clk);
    check("R9 status hold", status, 32'h08000000);
    check("R9 tcopy hold", tcopy, 32'h90005655);
    valid = '0; trap = 2'd0;

    // R8 stack bank swap
    preset(32'h0);
    bundle(1'b1, 2'd3, 32'hFFFFFFFF, 32'h00001000, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0);
    check("R8 sp bank0", sp, 32'h00001000);
    preset(32'h80000000);
    check("R8 sel set", {31'h0, sel}, 32'h1);
    check("R8 sp bank1 empty", sp, 32'h0);
    bundle(1'b1, 2'd3, 32'hFFFFFFFF, 32'h00003000, 1'b1, 2'd0, 32'h80000000, 32'h0, 1'b0, 2'd0);
    check("R8 sel clear", {31'h0, sel}, 32'h0);
    check("R8 sp back bank0", sp, 32'h00001000);
    preset(32'h80000000);
    check("R8 sp saved bank1", sp, 32'h00003000);
    // R8 normal trap keeps SM, debug trap clears it
    bundle(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 2'd2);
    check("R8 debug trap sel", {31'h0, sel}, 32'h0);
    check("R8 debug trap sp", sp, 32'h00001000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule